// File: doc/BRIEF.md
# Monitor Composite Sync Generator

This block sits between a video timing controller and a monitor. The controller produces a wide horizontal sync window and a multi-line vertical sync window. The block cuts a shorter monitor pulse out of each window, with a fixed start delay and a maximum length. It then merges the two pulses into one active-low composite sync line. While the controller's horizontal sync is asserted, the block also raises a flag that tells the pixel path to output the palette black level.

Time is measured in character periods. A one-cycle `char_en` strobe on the system clock marks the end of each period. The horizontal window counts character periods while `hsync_in` is high. The vertical window counts falling edges of `hsync_in` (line ends) while `vsync_in` is high. Both windows are instances of one small state machine with these states:

- `W_IDLE`: the input sync is low.
- `W_LEAD`: the start delay is running.
- `W_PULSE`: the monitor pulse is active.
- `W_TAIL`: the window is used up but the input is still high.

The transitions are:

- idle→lead when the input rises.
- lead→pulse when the count reaches the delay.
- pulse→tail when the count reaches delay plus width.
- any state→idle when the input falls.

The count saturates at delay plus width, so a long input cannot re-trigger a pulse.

Top module: `csync_gen`

## Requirements
- R1: `force_black` is high in every cycle in which `hsync_in` is high, and low otherwise.
- R2: The horizontal monitor pulse is inactive during the first 2 character periods of an `hsync_in` window and starts with the third.
- R3: The horizontal monitor pulse lasts at most 4 character periods. With `hsync_in` high from character 46 for 14 characters, the pulse covers characters 48 to 51 inclusive.
- R4: When `hsync_in` falls before the horizontal window completes, the horizontal pulse ends in the same character. An `hsync_in` of 2 characters or fewer produces no pulse.
- R5: The vertical monitor pulse starts once two line ends (falling edges of `hsync_in`, seen at `char_en`) have occurred while `vsync_in` is high.
- R6: The vertical monitor pulse lasts until two more line ends have occurred, and ends early when `vsync_in` falls.
- R7: `csync_n` is low exactly when the horizontal or the vertical monitor pulse is active (logical OR, active low).
- R8: The counters saturate. An `hsync_in` window of any length yields a single 4-character pulse, and a long `vsync_in` yields a single 2-line pulse.
- R9: After reset, with both sync inputs low, `csync_n` is 1 and `force_black` is 0.
- R10: Each counter clears when its input sync goes low, so every new sync window produces its own full pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_en | input | 1 | One-cycle strobe at the end of each character period |
| hsync_in | input | 1 | Horizontal sync window from the timing controller, active high |
| vsync_in | input | 1 | Vertical sync window from the timing controller, active high |
| csync_n | output | 1 | Composite monitor sync, active low |
| force_black | output | 1 | Forces the pixel path to palette black |

## Verification
The assertions check four rules on every cycle:

- No monitor pulse is present once its input sync is low.
- Neither pulse is active in the first cycle of a new input window.
- A low `csync_n` always has an active input sync behind it.
- `force_black` covers the horizontal sync.

Only the bench scenarios can show the exact placement of the pulses. These include the 46/14 example, truncation of short windows, saturation under very long windows, the line counting of the vertical pulse, and the restart of back-to-back windows.

// File: rtl/csync_pkg.sv
package csync_pkg;
    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_LEAD  = 2'd1,
        W_PULSE = 2'd2,
        W_TAIL  = 2'd3
    } win_state_t;
endpackage

// File: rtl/csync_fall_detect.sv
module csync_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sig,
    output logic fall
);
    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  sig_q <= 1'b0;
        else if (en) sig_q <= sig;
    end

    // Value of the previous character was high, the current one is low.
    assign fall = en & sig_q & ~sig;
endmodule

// File: rtl/csync_window.sv
module csync_window
    import csync_pkg::*;
#(
    parameter int DELAY = 2,
    parameter int WIDTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic adv,
    output logic pulse
);
    localparam int LIMIT = DELAY + WIDTH;
    localparam int CW    = $clog2(LIMIT + 1);

    win_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d, cnt_inc;

    function automatic win_state_t classify(input logic [CW-1:0] c);
        if (int'(c) < DELAY)      return W_LEAD;
        else if (int'(c) < LIMIT) return W_PULSE;
        else                      return W_TAIL;
    endfunction

    // Saturating increment: the count never wraps back into the window.
    assign cnt_inc = (int'(cnt_q) >= LIMIT) ? cnt_q : cnt_q + CW'(1);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            W_IDLE: begin
                if (active) begin
                    cnt_d   = adv ? CW'(1) : '0;
                    state_d = classify(cnt_d);
                end
            end
            W_LEAD, W_PULSE, W_TAIL: begin
                if (!active) begin
                    cnt_d   = '0;
                    state_d = W_IDLE;
                end else if (adv) begin
                    cnt_d   = cnt_inc;
                    state_d = classify(cnt_d);
                end
            end
            default: begin
                cnt_d   = '0;
                state_d = W_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output is gated by the live input so an early end truncates at once.
    always_comb begin
        pulse = active && (state_q == W_PULSE);
    end
endmodule

// File: rtl/csync_gen.sv
module csync_gen #(
    parameter int H_DELAY = 2,
    parameter int H_WIDTH = 4,
    parameter int V_DELAY = 2,
    parameter int V_WIDTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic char_en,
    input  logic hsync_in,
    input  logic vsync_in,
    output logic csync_n,
    output logic force_black
);
    logic line_tick;
    logic h_pulse;
    logic v_pulse;

    csync_fall_detect u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (char_en),
        .sig   (hsync_in),
        .fall  (line_tick)
    );

    csync_window #(.DELAY(H_DELAY), .WIDTH(H_WIDTH)) u_hwin (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (hsync_in),
        .adv    (char_en),
        .pulse  (h_pulse)
    );

    csync_window #(.DELAY(V_DELAY), .WIDTH(V_WIDTH)) u_vwin (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (vsync_in),
        .adv    (line_tick),
        .pulse  (v_pulse)
    );

    assign force_black = hsync_in;
    assign csync_n     = ~(h_pulse | v_pulse);
endmodule

// File: rtl/csync_gen_chk.sv
module csync_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic hsync_in,
    input logic vsync_in,
    input logic csync_n,
    input logic force_black,
    input logic h_pulse,
    input logic v_pulse
);
    p_black_cover_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hsync_in |-> force_black);

    p_no_early_h_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_in) |-> !h_pulse);

    p_trunc_h_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_in |-> !h_pulse);

    p_no_early_v_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync_in) |-> !v_pulse);

    p_trunc_v_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_in |-> !v_pulse);

    p_sync_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !csync_n |-> (hsync_in || vsync_in));
endmodule

bind csync_gen csync_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hsync_in    (hsync_in),
    .vsync_in    (vsync_in),
    .csync_n     (csync_n),
    .force_black (force_black),
    .h_pulse     (h_pulse),
    .v_pulse     (v_pulse)
);

// File: tb/csync_gen_bench.sv
module csync_gen_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic char_en = 1'b0;
    logic hsync_in = 1'b0;
    logic vsync_in = 1'b0;
    logic csync_n;
    logic force_black;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic  exp_c;
        logic  exp_b;
        string req;
    } item_t;

    item_t q[$];
    event  samp;
    string cur_req = "R9";

    // Reference model state, updated at each character end.
    int hrun = 0;
    int vlines = 0;
    bit hprev = 0;

    always #10 clk = ~clk;

    csync_gen u_csync_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .char_en     (char_en),
        .hsync_in    (hsync_in),
        .vsync_in    (vsync_in),
        .csync_n     (csync_n),
        .force_black (force_black)
    );

    // Monitor: pops the expected item for the current character and compares.
    always @(samp) begin
        item_t it;
        if (q.size() == 0) begin
            bad++;
            $display("FAIL %s scoreboard empty actual=none expected=item", cur_req);
        end else begin
            it = q.pop_front();
            total++;
            if (csync_n !== it.exp_c) begin
                bad++;
                $display("FAIL %s csync_n actual=%b expected=%b", it.req, csync_n, it.exp_c);
            end
            total++;
            if (force_black !== it.exp_b) begin
                bad++;
                $display("FAIL R1 force_black actual=%b expected=%b", force_black, it.exp_b);
            end
        end
    end

    task automatic drive_char(input bit h, input bit v);
        bit eh;
        bit ev;
        item_t it;
        eh = h && hrun >= 2 && hrun < 6;
        ev = v && vlines >= 2 && vlines < 4;
        @(negedge clk);
        char_en  = 1'b0;
        hsync_in = h;
        vsync_in = v;
        it.exp_c = ~(eh | ev);
        it.exp_b = h;
        it.req   = cur_req;
        q.push_back(it);
        @(negedge clk);
        ->samp;
        @(negedge clk);
        @(negedge clk);
        char_en = 1'b1;
        if (h) hrun = (hrun < 6) ? hrun + 1 : 6;
        else   hrun = 0;
        if (!v)                vlines = 0;
        else if (hprev && !h)  vlines = (vlines < 4) ? vlines + 1 : 4;
        hprev = h;
    endtask

    task automatic drive_line(input int len, input int hs, input int hl, input bit v);
        for (int c = 0; c < len; c++)
            drive_char((c >= hs) && (c < hs + hl), v);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state with quiet inputs
        cur_req = "R9";
        drive_char(0, 0);
        drive_char(0, 0);
        // R2 and R3: window 46..59, pulse 48..51
        cur_req = "R3";
        drive_line(64, 46, 14, 0);
        cur_req = "R2";
        drive_line(20, 3, 8, 0);
        // R4: truncated windows
        cur_req = "R4";
        drive_line(16, 2, 4, 0);
        drive_line(16, 5, 2, 0);
        drive_line(16, 5, 1, 0);
        // R8: very long horizontal window gives one pulse only
        cur_req = "R8";
        drive_line(48, 2, 40, 0);
        // R10: back-to-back windows each restart
        cur_req = "R10";
        for (int k = 0; k < 3; k++) drive_line(12, 1, 8, 0);
        // R5, R6, R7: vertical window spanning 6 lines
        cur_req = "R5";
        for (int k = 0; k < 3; k++) drive_line(16, 4, 6, 1);
        cur_req = "R7";
        for (int k = 0; k < 3; k++) drive_line(16, 4, 6, 1);
        cur_req = "R6";
        drive_line(16, 4, 6, 0);
        // R6: vertical window ending early, mid-pulse
        for (int k = 0; k < 2; k++) drive_line(16, 4, 6, 1);
        drive_line(8, 4, 3, 1);
        drive_line(16, 4, 6, 0);
        // R8: long vertical window gives one 2-line pulse
        cur_req = "R8";
        for (int k = 0; k < 8; k++) drive_line(12, 2, 3, 1);
        // R10: new vertical window restarts the count
        cur_req = "R10";
        drive_line(12, 2, 3, 0);
        for (int k = 0; k < 4; k++) drive_line(12, 2, 3, 1);
        drive_char(0, 0);
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule